// File: doc/BRIEF.md
# Variable-Length Integrate-and-Dump Despreader

This block is the prompt-channel correlator of a direct-sequence spread-spectrum receiver. The chip rate is not an integer multiple of the symbol rate, so symbols are either 749 or 750 chips long. Each soft chip sample is multiplied by the local spreading chip. The products are summed over one data symbol, and the total is dumped as a soft decision together with its sign as a hard bit. The accumulator then clears for the next symbol.

The receiver front end runs at two samples per chip and marks the on-time sample of each pair. Only on-time samples that are also valid enter the correlator. A single accumulator serves both symbol lengths; only the dump instant moves. A remainder register decides the length of each symbol. It gains a fixed step per symbol modulo a fixed modulus, and the symbol gets one extra chip whenever that addition wraps. Chip alignment, code acquisition, tracking loops and carrier recovery are handled upstream.

Top module: `var_len_despreader`

## Requirements
- R1: After reset, sum_o is 0, dump_valid_o is 0 and hard_bit_o is 0.
- R2: A sample counts as a chip only when smp_valid_i and smp_ontime_i are both 1 at a rising clock edge. All other samples change neither the running sum nor the symbol length.
- R3: code_i = 0 adds the sample unchanged to the running sum; code_i = 1 adds its two's-complement negation.
- R4: When the last chip of a symbol is taken, the sum of that symbol's products appears on sum_o in the next cycle, and dump_valid_o is 1 for exactly that one cycle.
- R5: A remainder r starts at 0 on reset. For each symbol, r + 137 is formed. If it is 512 or more, the symbol has 750 chips and r becomes r + 137 - 512. Otherwise the symbol has 749 chips and r becomes r + 137. The resulting lengths from reset are 749, 749, 749, 750, 749, 749, 749, 750, ...
- R6: Each symbol's sum starts from zero. Nothing from an earlier symbol carries into it.
- R7: hard_bit_o is 1 exactly when the dumped sum is negative. sum_o and hard_bit_o hold their values until the next dump.
- R8: Samples are signed 8-bit. An 18-bit signed sum holds 750 chips of magnitude 128 of either sign without wrapping (-96000 and +96000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_ontime_i | input | 1 | Sample is the on-time half of the chip pair |
| smp_i | input | 8 | Signed soft chip sample |
| code_i | input | 1 | Local spreading chip, 1 means negate |
| sum_o | output | 18 | Signed dumped symbol sum |
| dump_valid_o | output | 1 | One-cycle strobe for a new sum |
| hard_bit_o | output | 1 | Sign of the dumped sum |

## Verification
A constant positive sample with a zero code checks that the sample passes through unchanged. The same constant with an inverting code checks negation and the negative hard bit. A pseudo-random sample and code stream, run across the symbols that must take 750 chips, shows whether the dump lands on exactly the right chip and whether any earlier sum leaks into the next symbol. Samples that are late-phase or invalid, interleaved with the real chips, show whether anything other than a valid on-time sample reaches the sum. Full-scale -128 runs under both code values probe the accumulator at its extremes.

// File: rtl/despread_pkg.sv
package despread_pkg;

  // signed width holding max_len samples of magnitude 2**(smp_w-1)
  function automatic int acc_width(input int smp_w, input int max_len);
    return $clog2(max_len * (1 << (smp_w - 1)) + 1) + 1;
  endfunction

  typedef enum logic {
    CHIP_PASS   = 1'b0,
    CHIP_INVERT = 1'b1
  } chip_pol_e;

endpackage

// File: rtl/chip_mult.sv
module chip_mult #(
  parameter int SMP_W = 8,
  parameter int OUT_W = 18
) (
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic                    code_i,
  output logic signed [OUT_W-1:0] prod_o
);
  import despread_pkg::*;

  logic signed [OUT_W-1:0] ext;
  chip_pol_e               pol;

  always_comb begin
    ext    = OUT_W'(smp_i);
    pol    = chip_pol_e'(code_i);
    prod_o = (pol == CHIP_INVERT) ? -ext : ext;
  end

endmodule

// File: rtl/symbol_len_ctrl.sv
module symbol_len_ctrl #(
  parameter int BASE_LEN  = 749,
  parameter int FRAC_STEP = 137,
  parameter int FRAC_MOD  = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_en_i,
  output logic last_o
);
  localparam int CNT_W  = $clog2(BASE_LEN + 1);
  localparam int FRAC_W = $clog2(FRAC_MOD);

  logic [CNT_W-1:0]  cnt_q, last_idx;
  logic [FRAC_W-1:0] frac_q, frac_nxt;
  logic [FRAC_W:0]   frac_sum;
  logic              extra;

  always_comb begin
    frac_sum = {1'b0, frac_q} + (FRAC_W+1)'(FRAC_STEP);
    extra    = frac_sum >= (FRAC_W+1)'(FRAC_MOD);
    frac_nxt = extra ? FRAC_W'(frac_sum - (FRAC_W+1)'(FRAC_MOD)) : FRAC_W'(frac_sum);
    last_idx = extra ? CNT_W'(BASE_LEN) : CNT_W'(BASE_LEN - 1);
    last_o   = chip_en_i && (cnt_q == last_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      frac_q <= '0;
    end else if (chip_en_i) begin
      if (last_o) begin
        cnt_q  <= '0;
        frac_q <= frac_nxt;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R5
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BASE_LEN));

  // R5
  frac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> $stable(frac_q));

  // R2
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |=> $stable(cnt_q));

endmodule

// File: rtl/integ_dump.sv
module integ_dump #(
  parameter int ACC_W = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    chip_en_i,
  input  logic                    last_i,
  input  logic signed [ACC_W-1:0] prod_i,
  output logic signed [ACC_W-1:0] sum_o,
  output logic                    dump_valid_o,
  output logic                    hard_bit_o
);
  logic signed [ACC_W-1:0] acc_q, acc_nxt;

  assign acc_nxt = acc_q + prod_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= '0;
      sum_o        <= '0;
      dump_valid_o <= 1'b0;
      hard_bit_o   <= 1'b0;
    end else begin
      dump_valid_o <= 1'b0;
      if (chip_en_i) begin
        if (last_i) begin
          sum_o        <= acc_nxt;
          hard_bit_o   <= acc_nxt[ACC_W-1];
          dump_valid_o <= 1'b1;
          acc_q        <= '0;
        end else begin
          acc_q <= acc_nxt;
        end
      end
    end
  end

  // R4
  dump_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_valid_o |=> !dump_valid_o);

  // R7
  sum_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dump_valid_o |-> $stable(sum_o) && $stable(hard_bit_o));

  // R6
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_valid_o |-> acc_q == '0);

  // R2
  acc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |=> $stable(acc_q));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_en_i && (acc_q[ACC_W-1] == prod_i[ACC_W-1]) |-> acc_nxt[ACC_W-1] == acc_q[ACC_W-1]);

endmodule

// File: rtl/var_len_despreader.sv
module var_len_despreader #(
  parameter int SMP_W     = 8,
  parameter int BASE_LEN  = 749,
  parameter int FRAC_STEP = 137,
  parameter int FRAC_MOD  = 512,
  localparam int MAX_LEN  = BASE_LEN + 1,
  localparam int ACC_W    = despread_pkg::acc_width(SMP_W, MAX_LEN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_valid_i,
  input  logic                    smp_ontime_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic                    code_i,
  output logic signed [ACC_W-1:0] sum_o,
  output logic                    dump_valid_o,
  output logic                    hard_bit_o
);
  logic                    chip_en, last_chip;
  logic signed [ACC_W-1:0] prod;

  // prompt channel: on-time half of each chip pair only
  assign chip_en = smp_valid_i && smp_ontime_i;

  chip_mult #(.SMP_W(SMP_W), .OUT_W(ACC_W)) u_mult (
    .smp_i  (smp_i),
    .code_i (code_i),
    .prod_o (prod)
  );

  symbol_len_ctrl #(
    .BASE_LEN (BASE_LEN),
    .FRAC_STEP(FRAC_STEP),
    .FRAC_MOD (FRAC_MOD)
  ) u_len (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chip_en_i (chip_en),
    .last_o    (last_chip)
  );

  integ_dump #(.ACC_W(ACC_W)) u_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .chip_en_i    (chip_en),
    .last_i       (last_chip),
    .prod_i       (prod),
    .sum_o        (sum_o),
    .dump_valid_o (dump_valid_o),
    .hard_bit_o   (hard_bit_o)
  );

endmodule

// File: tb/sim_var_len_despreader.sv
module sim_var_len_despreader;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 200000;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               smp_valid_i = 1'b0;
  logic               smp_ontime_i = 1'b0;
  logic signed [7:0]  smp_i = '0;
  logic               code_i = 1'b0;
  logic signed [17:0] sum_o;
  logic               dump_valid_o;
  logic               hard_bit_o;

  int n_chk = 0, n_fail = 0;
  int frac_m = 0;
  int sym_no = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  var_len_despreader u0 (
    .clk_i, .rst_ni, .smp_valid_i, .smp_ontime_i, .smp_i, .code_i,
    .sum_o, .dump_valid_o, .hard_bit_o
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic raw(input bit v, input bit ot, input int s, input bit c);
    smp_valid_i  = v;
    smp_ontime_i = ot;
    smp_i        = s[7:0];
    code_i       = c;
    @(posedge clk_i);
    @(negedge clk_i);
    smp_valid_i  = 1'b0;
    smp_ontime_i = 1'b0;
  endtask

  task automatic gen(input int mode, input int i, output int s, output bit c);
    case (mode)
      0: begin s = 5;    c = 1'b0; end
      1: begin s = 7;    c = 1'b1; end
      2: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        s = int'($signed(lfsr[7:0]));
        c = lfsr[8];
      end
      3: begin s = -128; c = 1'b0; end
      4: begin s = -128; c = 1'b1; end
      default: begin s = 3 + (i % 4); c = i[0]; end
    endcase
  endtask

  // runs one symbol from the bench's own length rule; returns expected sum
  task automatic run_symbol(input int mode, input string req, output int exp);
    int len, s;
    bit c, early;
    sym_no++;
    if (frac_m + 137 >= 512) begin len = 750; frac_m = frac_m + 137 - 512; end
    else begin len = 749; frac_m = frac_m + 137; end
    exp = 0;
    early = 0;
    for (int i = 0; i < len; i++) begin
      gen(mode, i, s, c);
      if (mode == 5) begin
        raw(1'b1, 1'b0, 100, 1'b0);   // late-phase sample, must be ignored
        raw(1'b0, 1'b1, -100, 1'b1);  // invalid sample, must be ignored
        if (dump_valid_o) early = 1;
      end
      exp += c ? -s : s;
      raw(1'b1, 1'b1, s, c);
      if (i < len - 1 && dump_valid_o) early = 1;
    end
    check(!early && dump_valid_o, "R5", $sformatf("symbol %0d dump after chip %0d", sym_no, len),
          int'(dump_valid_o && !early), 1);
    check(int'(sum_o) == exp, req, $sformatf("symbol %0d sum", sym_no), int'(sum_o), exp);
    check(hard_bit_o == (exp < 0), "R7", $sformatf("symbol %0d hard bit", sym_no),
          int'(hard_bit_o), int'(exp < 0));
  endtask

  task automatic t_reset();
    check(int'(sum_o) == 0, "R1", "reset sum", int'(sum_o), 0);
    check(dump_valid_o == 1'b0, "R1", "reset dump_valid", int'(dump_valid_o), 0);
    check(hard_bit_o == 1'b0, "R1", "reset hard bit", int'(hard_bit_o), 0);
  endtask

  task automatic t_pass_through();
    int e;
    run_symbol(0, "R3", e);
    check(e == 3745, "R3", "pass-through model", e, 3745);
    raw(1'b0, 1'b0, 0, 1'b0);
    check(dump_valid_o == 1'b0, "R4", "strobe lasts one cycle", int'(dump_valid_o), 0);
  endtask

  task automatic t_negate_and_hold();
    int e;
    run_symbol(1, "R6", e);  // would show the previous symbol's sum if not cleared
    check(int'(sum_o) == -5243, "R3", "negated sum", int'(sum_o), -5243);
    for (int k = 0; k < 6; k++) raw(1'b0, 1'b1, 99, 1'b0);
    check(int'(sum_o) == -5243, "R7", "sum held between dumps", int'(sum_o), -5243);
    check(hard_bit_o == 1'b1, "R7", "hard bit held", int'(hard_bit_o), 1);
    check(dump_valid_o == 1'b0, "R4", "no strobe while idle", int'(dump_valid_o), 0);
  endtask

  task automatic t_ignore_gaps();
    int e;
    run_symbol(5, "R2", e);
  endtask

  task automatic t_random_long();
    int e;
    run_symbol(2, "R5", e);  // symbol 4: 750 chips
    run_symbol(2, "R6", e);
  endtask

  task automatic t_fill_to_eight();
    int e;
    run_symbol(0, "R4", e);
    run_symbol(1, "R4", e);
    run_symbol(3, "R8", e);  // symbol 8: 750 chips of -128
    check(int'(sum_o) == -96000, "R8", "full-scale negative", int'(sum_o), -96000);
  endtask

  task automatic t_full_scale_pos();
    int e;
    run_symbol(4, "R8", e);
    check(int'(sum_o) == 95872, "R8", "749 chips negated", int'(sum_o), 95872);
    run_symbol(2, "R5", e);
    run_symbol(2, "R5", e);
    run_symbol(4, "R8", e);  // symbol 12: 750 chips
    check(int'(sum_o) == 96000, "R8", "full-scale positive", int'(sum_o), 96000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d cycles", WDOG_CYC, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_pass_through();
    t_negate_and_hold();
    t_ignore_gaps();
    t_random_long();
    t_fill_to_eight();
    t_full_scale_pos();
    finish_run();
  end

endmodule